// File: doc/BRIEF.md
# Frame-Size-Dependent Dual Word FIFO

This block holds the transmit and receive word queues of a serial peripheral controller. Each queue has a fixed physical storage, but the number of entries it admits is picked at run time from two configuration inputs: a deep-mode enable and a 6-bit frame-size field. Small frames get a deep queue, wide frames a shallower one. With deep mode off, both queues admit a small fixed number of entries.

On the transmit side, a write port pushes words and the serial engine pops them. On the receive side, the serial engine pushes words and a read port pops them. Each queue tracks its fill level in a four-state machine:

- **EMPTY**: occupancy 0.
- **PARTIAL**: occupancy between 1 and depth minus 2.
- **NEAR_FULL**: occupancy equal to depth minus 1.
- **FULL**: occupancy at or above depth.

Every clock the machine moves to the state that the next occupancy and the current depth select. The named transitions are:

- **fill**: a push moves it one level up.
- **drain**: a pop moves it one level down.
- **clear**: a queue clear returns it to EMPTY from any state.
- **reclass**: a depth change re-sorts the state without any push or pop.

The flags empty, full and full-next decode directly from this state. The receive queue also keeps an overflow status bit and a sticky raw overflow event bit.

Top module: `dfifo_top`

## Requirements
- R1: With deep mode off, each queue admits exactly 4 words, whatever the frame size is.
- R2: With deep mode on, each queue admits 32 words for a frame size of 8 or less. It admits 16 words for a frame size of 9 to 16, and 8 words for a frame size of 17 or more.
- R3: Words leave each queue in the order they entered. The read data output always shows the oldest stored word.
- R4: A transmit push while the occupancy is at or above the depth is discarded, and the stored words are unchanged.
- R5: A receive push while the occupancy is at or above the depth stores nothing. It sets both the overflow status and the raw overflow bit.
- R6: Full-next is 1 exactly when the occupancy equals depth minus 1. Full is 1 when the occupancy is at or above the depth. Both drop again as words are popped.
- R7: Empty is 1 when no word is stored, which includes right after the last word is popped. A pop of an empty queue returns 0 and changes nothing.
- R8: A receive-side read (pop strobe) clears the overflow status unless a new overflow occurs in the same cycle. The raw overflow bit stays set until the overflow acknowledge input is pulsed.
- R9: A queue clear empties that queue: empty is set, and full and full-next are cleared. The clear wins over a push or pop in the same cycle.
- R10: After reset, both queues are empty, no full, full-next or overflow flag is set, and both read data outputs are 0.
- R11: All flags change on the clock edge that accepts the push, pop or clear, and not before.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| deep_en | input | 1 | Deep-mode enable for depth selection |
| frame_size | input | 6 | Configured frame width in bits |
| tx_clr | input | 1 | Clear transmit queue |
| rx_clr | input | 1 | Clear receive queue |
| tx_push | input | 1 | Push tx_wdata into transmit queue |
| tx_wdata | input | 32 | Transmit word to store |
| tx_pop | input | 1 | Serial engine pops transmit head |
| tx_rdata | output | 32 | Oldest transmit word, 0 when empty |
| tx_empty | output | 1 | Transmit queue empty |
| tx_full | output | 1 | Transmit queue full |
| tx_full_next | output | 1 | Transmit queue one entry short of full |
| rx_push | input | 1 | Serial engine pushes rx_wdata |
| rx_wdata | input | 32 | Received word to store |
| rx_pop | input | 1 | Read port pops receive head |
| rx_rdata | output | 32 | Oldest receive word, 0 when empty |
| rx_empty | output | 1 | Receive queue empty |
| rx_full | output | 1 | Receive queue full |
| rx_full_next | output | 1 | Receive queue one entry short of full |
| rx_ovf_ack | input | 1 | Clears the raw overflow bit |
| rx_ovf_stat | output | 1 | Overflow status, cleared by a receive read |
| rx_ovf_raw | output | 1 | Sticky overflow event bit |

## Verification
The fill-and-drain pattern runs on the transmit queue for each configuration pair in a vector table. The table holds deep mode off at small and large frame sizes, and deep mode on at frame sizes 0, 8, 9, 16, 17 and 32. Each step from 8 to 9 and from 16 to 17 tells one depth band from its neighbour. Filling past the limit separates a dropped push from a stored one, and the drain order exposes any reordering or a stored overflow word. A directed receive sequence overflows a 4-entry queue and then reads it out. This separates the overflow status, which a read clears, from the raw bit, which only the acknowledge clears. It also shows the full-next flag clearing as the occupancy falls. Further directed cases cover clear racing a push, a pop of an empty queue, and the exact edge at which the flags move.

// File: rtl/dfifo_pkg.sv
package dfifo_pkg;

    // Fill level of one queue, decoded into the status flags.
    typedef enum logic [1:0] {
        LVL_EMPTY   = 2'd0,
        LVL_PARTIAL = 2'd1,
        LVL_NEAR    = 2'd2,
        LVL_FULL    = 2'd3
    } fill_state_t;

    // Sort an occupancy against the active depth into a fill level.
    function automatic fill_state_t classify_fill(input int unsigned cnt,
                                                  input int unsigned dep);
        fill_state_t lvl;
        if (cnt == 0)
            lvl = LVL_EMPTY;
        else if (cnt >= dep)
            lvl = LVL_FULL;
        else if (cnt == dep - 1)
            lvl = LVL_NEAR;
        else
            lvl = LVL_PARTIAL;
        return lvl;
    endfunction

endpackage

// File: rtl/dfifo_depth_sel.sv
module dfifo_depth_sel #(
    parameter int STORE_DEPTH   = 32,
    parameter int SHALLOW_DEPTH = 4,
    parameter int FS_W          = 6,
    parameter int NARROW_MAX    = 8,
    parameter int MID_MAX       = 16,
    localparam int CNT_W        = $clog2(STORE_DEPTH) + 1
) (
    input  logic             deep_en_i,
    input  logic [FS_W-1:0]  frame_size_i,
    output logic [CNT_W-1:0] depth_o
);
    // Depth bands: full storage, half storage, quarter storage.
    localparam logic [CNT_W-1:0] DEPTH_NARROW  = CNT_W'(STORE_DEPTH);
    localparam logic [CNT_W-1:0] DEPTH_MID     = CNT_W'(STORE_DEPTH / 2);
    localparam logic [CNT_W-1:0] DEPTH_WIDE    = CNT_W'(STORE_DEPTH / 4);
    localparam logic [CNT_W-1:0] DEPTH_SHALLOW = CNT_W'(SHALLOW_DEPTH);

    always_comb begin
        if (!deep_en_i)
            depth_o = DEPTH_SHALLOW;
        else if (int'(frame_size_i) <= NARROW_MAX)
            depth_o = DEPTH_NARROW;
        else if (int'(frame_size_i) <= MID_MAX)
            depth_o = DEPTH_MID;
        else
            depth_o = DEPTH_WIDE;
    end
endmodule

// File: rtl/dfifo_word.sv
module dfifo_word
    import dfifo_pkg::*;
#(
    parameter int WORD_W      = 32,
    parameter int STORE_DEPTH = 32,
    parameter bit OVF_TRACK   = 1'b0,
    localparam int PTR_W      = $clog2(STORE_DEPTH),
    localparam int CNT_W      = PTR_W + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_i,
    input  logic [CNT_W-1:0]  depth_i,
    input  logic              push_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              pop_i,
    input  logic              ovf_ack_i,
    output logic [WORD_W-1:0] rdata_o,
    output logic              empty_o,
    output logic              full_o,
    output logic              full_next_o,
    output logic              ovf_stat_o,
    output logic              ovf_raw_o
);
    localparam logic [PTR_W-1:0] PTR_LAST = PTR_W'(STORE_DEPTH - 1);

    logic [WORD_W-1:0] mem_q [STORE_DEPTH];
    logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
    logic [CNT_W-1:0]  count_q, count_d;
    fill_state_t       state_q, state_d;
    logic              accept_push, accept_pop, push_drop;

    assign accept_push = push_i && (count_q < depth_i) && !clr_i;
    assign accept_pop  = pop_i  && (count_q != '0)     && !clr_i;
    assign push_drop   = push_i && (count_q >= depth_i) && !clr_i;

    function automatic logic [PTR_W-1:0] ptr_next(input logic [PTR_W-1:0] p);
        return (p == PTR_LAST) ? '0 : p + 1'b1;
    endfunction

    // Next occupancy
    always_comb begin
        count_d = count_q;
        if (clr_i)
            count_d = '0;
        else if (accept_push && !accept_pop)
            count_d = count_q + 1'b1;
        else if (!accept_push && accept_pop)
            count_d = count_q - 1'b1;
    end

    // Storage and pointers
    always_ff @(posedge clk) begin
        if (accept_push)
            mem_q[wr_ptr_q] <= wdata_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (clr_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept_push) wr_ptr_q <= ptr_next(wr_ptr_q);
            if (accept_pop)  rd_ptr_q <= ptr_next(rd_ptr_q);
            count_q <= count_d;
        end
    end

    // Fill-level machine: next state from next occupancy and active depth
    always_comb begin
        state_d = classify_fill(int'(count_d), int'(depth_i));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= LVL_EMPTY;
        else
            state_q <= state_d;
    end

    // Flag decode
    always_comb begin
        empty_o     = 1'b0;
        full_o      = 1'b0;
        full_next_o = 1'b0;
        unique case (state_q)
            LVL_EMPTY:   empty_o     = 1'b1;
            LVL_PARTIAL: ;
            LVL_NEAR:    full_next_o = 1'b1;
            LVL_FULL:    full_o      = 1'b1;
        endcase
    end

    assign rdata_o = (count_q == '0) ? '0 : mem_q[rd_ptr_q];

    // Overflow tracking, receive variant only
    generate
        if (OVF_TRACK) begin : g_ovf
            logic stat_q, raw_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    stat_q <= 1'b0;
                    raw_q  <= 1'b0;
                end else begin
                    if (push_drop)
                        stat_q <= 1'b1;
                    else if (pop_i)
                        stat_q <= 1'b0;
                    if (push_drop)
                        raw_q <= 1'b1;
                    else if (ovf_ack_i)
                        raw_q <= 1'b0;
                end
            end
            assign ovf_stat_o = stat_q;
            assign ovf_raw_o  = raw_q;

            assert_rx_overflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
                (push_i && !clr_i && count_q >= depth_i) |=> (ovf_stat_o && ovf_raw_o));
        end else begin : g_no_ovf
            logic unused_ack;
            assign unused_ack = ovf_ack_i;
            assign ovf_stat_o = 1'b0;
            assign ovf_raw_o  = 1'b0;
        end
    endgenerate

    assert_push_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && !clr_i && count_q >= depth_i) |=> $stable(count_q));

    assert_empty_pop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && !clr_i && empty_o) |=> (empty_o && $stable(rd_ptr_q)));

    assert_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (empty_o && !full_o && !full_next_o && rdata_o == '0));

    assert_flag_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({empty_o, full_o, full_next_o}) <= 1);
endmodule

// File: rtl/dfifo_top.sv
module dfifo_top #(
    parameter int WORD_W        = 32,
    parameter int STORE_DEPTH   = 32,
    parameter int SHALLOW_DEPTH = 4,
    parameter int FS_W          = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              deep_en,
    input  logic [FS_W-1:0]   frame_size,
    input  logic              tx_clr,
    input  logic              rx_clr,
    input  logic              tx_push,
    input  logic [WORD_W-1:0] tx_wdata,
    input  logic              tx_pop,
    output logic [WORD_W-1:0] tx_rdata,
    output logic              tx_empty,
    output logic              tx_full,
    output logic              tx_full_next,
    input  logic              rx_push,
    input  logic [WORD_W-1:0] rx_wdata,
    input  logic              rx_pop,
    output logic [WORD_W-1:0] rx_rdata,
    output logic              rx_empty,
    output logic              rx_full,
    output logic              rx_full_next,
    input  logic              rx_ovf_ack,
    output logic              rx_ovf_stat,
    output logic              rx_ovf_raw
);
    localparam int CNT_W = $clog2(STORE_DEPTH) + 1;

    logic [CNT_W-1:0] depth_s;
    logic             tx_unused_stat, tx_unused_raw;

    dfifo_depth_sel #(
        .STORE_DEPTH  (STORE_DEPTH),
        .SHALLOW_DEPTH(SHALLOW_DEPTH),
        .FS_W         (FS_W)
    ) u_depth (
        .deep_en_i   (deep_en),
        .frame_size_i(frame_size),
        .depth_o     (depth_s)
    );

    dfifo_word #(
        .WORD_W     (WORD_W),
        .STORE_DEPTH(STORE_DEPTH),
        .OVF_TRACK  (1'b0)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (tx_clr),
        .depth_i    (depth_s),
        .push_i     (tx_push),
        .wdata_i    (tx_wdata),
        .pop_i      (tx_pop),
        .ovf_ack_i  (1'b0),
        .rdata_o    (tx_rdata),
        .empty_o    (tx_empty),
        .full_o     (tx_full),
        .full_next_o(tx_full_next),
        .ovf_stat_o (tx_unused_stat),
        .ovf_raw_o  (tx_unused_raw)
    );

    dfifo_word #(
        .WORD_W     (WORD_W),
        .STORE_DEPTH(STORE_DEPTH),
        .OVF_TRACK  (1'b1)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .clr_i      (rx_clr),
        .depth_i    (depth_s),
        .push_i     (rx_push),
        .wdata_i    (rx_wdata),
        .pop_i      (rx_pop),
        .ovf_ack_i  (rx_ovf_ack),
        .rdata_o    (rx_rdata),
        .empty_o    (rx_empty),
        .full_o     (rx_full),
        .full_next_o(rx_full_next),
        .ovf_stat_o (rx_ovf_stat),
        .ovf_raw_o  (rx_ovf_raw)
    );
endmodule

// File: tb/dfifo_top_bench.sv
module dfifo_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        deep_en = 1'b0;
    logic [5:0]  frame_size = 6'd8;
    logic        tx_clr = 1'b0, rx_clr = 1'b0;
    logic        tx_push = 1'b0, tx_pop = 1'b0;
    logic [31:0] tx_wdata = '0;
    logic [31:0] tx_rdata;
    logic        tx_empty, tx_full, tx_full_next;
    logic        rx_push = 1'b0, rx_pop = 1'b0, rx_ovf_ack = 1'b0;
    logic [31:0] rx_wdata = '0;
    logic [31:0] rx_rdata;
    logic        rx_empty, rx_full, rx_full_next, rx_ovf_stat, rx_ovf_raw;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    dfifo_top u_dfifo_top (
        .clk(clk), .rst_n(rst_n), .deep_en(deep_en), .frame_size(frame_size),
        .tx_clr(tx_clr), .rx_clr(rx_clr),
        .tx_push(tx_push), .tx_wdata(tx_wdata), .tx_pop(tx_pop), .tx_rdata(tx_rdata),
        .tx_empty(tx_empty), .tx_full(tx_full), .tx_full_next(tx_full_next),
        .rx_push(rx_push), .rx_wdata(rx_wdata), .rx_pop(rx_pop), .rx_rdata(rx_rdata),
        .rx_empty(rx_empty), .rx_full(rx_full), .rx_full_next(rx_full_next),
        .rx_ovf_ack(rx_ovf_ack), .rx_ovf_stat(rx_ovf_stat), .rx_ovf_raw(rx_ovf_raw)
    );

    // {deep_en, frame_size, expected depth}
    localparam logic [13:0] VEC [0:7] = '{
        {1'b0, 6'd8,  7'd4},
        {1'b0, 6'd30, 7'd4},
        {1'b1, 6'd0,  7'd32},
        {1'b1, 6'd8,  7'd32},
        {1'b1, 6'd9,  7'd16},
        {1'b1, 6'd16, 7'd16},
        {1'b1, 6'd17, 7'd8},
        {1'b1, 6'd32, 7'd8}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #2;
        tx_push = 1'b0; tx_pop = 1'b0; rx_push = 1'b0; rx_pop = 1'b0;
        tx_clr = 1'b0;  rx_clr = 1'b0; rx_ovf_ack = 1'b0;
    endtask

    task automatic txw(input logic [31:0] d);
        tx_push = 1'b1; tx_wdata = d; step();
    endtask

    task automatic txr(output logic [31:0] d);
        d = tx_rdata; tx_pop = 1'b1; step();
    endtask

    task automatic rxw(input logic [31:0] d);
        rx_push = 1'b1; rx_wdata = d; step();
    endtask

    task automatic rxr(output logic [31:0] d);
        d = rx_rdata; rx_pop = 1'b1; step();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] d;
        #3;
        // R10 reset state
        check("R10 tx_empty", 32'(tx_empty), 32'd1);
        check("R10 rx_empty", 32'(rx_empty), 32'd1);
        check("R10 flags", 32'({tx_full, tx_full_next, rx_full, rx_full_next, rx_ovf_stat, rx_ovf_raw}), 32'd0);
        check("R10 rdata", tx_rdata | rx_rdata, 32'd0);
        #10 rst_n = 1'b1;
        step();

        // Table walk: fill past depth, then drain
        foreach (VEC[i]) begin
            int dep;
            string tag;
            deep_en = VEC[i][13];
            frame_size = VEC[i][12:7];
            dep = int'(VEC[i][6:0]);
            tag = VEC[i][13] ? "R2" : "R1";
            tx_clr = 1'b1; rx_clr = 1'b1; step();
            step();
            for (int k = 1; k <= dep + 1; k++) begin
                txw(32'(k + 100 * i));
                if (k == dep - 1)
                    check("R6 near-full", 32'({tx_full_next, tx_full}), 32'b10);
                if (k == dep) begin
                    check({tag, " depth full"}, 32'({tx_full_next, tx_full}), 32'b01);
                end
                if (k == dep + 1)
                    check("R4 still full", 32'(tx_full), 32'd1);
            end
            for (int k = 1; k <= dep; k++) begin
                txr(d);
                check("R3 order", d, 32'(k + 100 * i));
            end
            check("R4 drop not stored", 32'(tx_empty), 32'd1);
            txr(d);
            check("R7 empty pop zero", d, 32'd0);
            check("R7 stays empty", 32'({tx_empty, tx_full_next}), 32'b10);
        end

        // Receive overflow sequence, depth 4
        deep_en = 1'b0;
        step();
        for (int k = 0; k < 4; k++) rxw(32'hA0 + 32'(k));
        check("R6 rx full", 32'(rx_full), 32'd1);
        check("R5 no ovf yet", 32'({rx_ovf_stat, rx_ovf_raw}), 32'd0);
        rxw(32'hFF);
        check("R5 ovf set", 32'({rx_ovf_stat, rx_ovf_raw}), 32'b11);
        rxr(d);
        check("R3 rx head", d, 32'hA0);
        check("R8 stat cleared raw kept", 32'({rx_ovf_stat, rx_ovf_raw}), 32'b01);
        check("R6 full-next on drain", 32'({rx_full, rx_full_next}), 32'b01);
        rx_ovf_ack = 1'b1; step();
        check("R8 raw acked", 32'(rx_ovf_raw), 32'd0);
        rxr(d);
        check("R3 rx second", d, 32'hA1);
        check("R6 full-next clears", 32'(rx_full_next), 32'd0);
        rxr(d);
        rxr(d);
        check("R5 overflow word not stored", d, 32'hA3);
        check("R7 rx empty after last", 32'(rx_empty), 32'd1);

        // Flag timing and clear priority
        tx_push = 1'b1; tx_wdata = 32'h55;
        #1;
        check("R11 no change before edge", 32'(tx_empty), 32'd1);
        step();
        check("R11 change at edge", 32'(tx_empty), 32'd0);
        txw(32'h66);
        tx_clr = 1'b1; tx_push = 1'b1; tx_wdata = 32'h77; step();
        check("R9 cleared empty", 32'({tx_empty, tx_full, tx_full_next}), 32'b100);
        check("R9 clear beats push", tx_rdata, 32'd0);

        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule